// File: doc/BRIEF.md
# Two-Cycle Saturating Q15 Multiplier

This unit is the multiply slice of a small processor's extended ALU. It takes two signed 16-bit operands, treats them as Q15 fixed-point fractions, and returns their product rescaled to Q15 and clamped to the 16-bit signed range. The multiply runs as a multi-cycle instruction. A start strobe loads the operands. A busy flag tells the core's stall logic to hold the pipeline. A one-cycle done pulse marks the clock in which the result is valid.

The arithmetic is split over two registered stages so that no single clock period carries the whole array.

- **First stage:** it detects each operand's sign, takes the magnitudes, forms two half-width partial products, and stores the exclusive-OR of the signs.
- **Second stage:** it adds the partial products, negates the sum when the stored sign bit is set, shifts right by the fraction width, and saturates.

Operand fetch and register writeback belong to the surrounding core.

Top module: `q15_sat_mul`

## Requirements
- R1: While reset is high and in the cycle after it is released, `busy`, `done` and `result` are all zero.
- R2: A `start` sampled high at a clock edge while `busy` is low is accepted. `busy` is then high for exactly the one following cycle.
- R3: `done` goes high only on the second clock edge after an accepted start. It stays high for exactly one cycle, and `result` holds the new product in that cycle.
- R4: `result` equals the signed product of `op_a` and `op_b` shifted right arithmetically by 15 bits. The shift rounds toward minus infinity.
- R5: The sign of the result follows the exclusive-OR of the operand signs. A zero operand gives zero whatever the other operand's sign.
- R6: A scaled product above 32767 saturates to 32767, so -32768 times -32768 gives 32767. A scaled product below -32768 saturates to -32768.
- R7: A `start` that arrives while `busy` is high is ignored. It produces no extra `done` pulse and does not change the result of the multiply in flight.
- R8: Between `done` pulses, `result` keeps its last value.
- R9: A new start may be issued in the same cycle that `done` is high. This gives one product every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply of the present operands |
| op_a | input | 16 | Multiplicand, two's complement Q15 |
| op_b | input | 16 | Multiplier, two's complement Q15 |
| busy | output | 1 | High while the first stage holds an operation; stall request |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 16 | Saturated Q15 product |

## Verification
The bound checker watches the control timing on every cycle:

- `busy` lasts one cycle after an accepted start.
- `done` follows `busy` and never repeats.
- A start seen while busy never extends the operation.
- The result stays stable whenever `done` is low.

The numeric value of each product can only be shown by the bench's scenarios. These cover sign combinations, zero operands, exact and truncated shifts, the single overflowing corner, back-to-back issue, and a start dropped during `busy`. The scoreboard compares each one against a product computed independently.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int unsigned SMUL_DATA_W = 16;
  localparam int unsigned SMUL_FRAC_W = 15;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done
);
  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      busy <= accept;
      done <= busy;
    end
  end
endmodule

// File: rtl/smul_stage1.sv
module smul_stage1 #(
  parameter int unsigned W = 16,
  parameter int unsigned H = W / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [W-1:0]          op_a,
  input  logic [W-1:0]          op_b,
  output logic [W+H-1:0]        pp_lo,
  output logic [2*W-H-1:0]      pp_hi,
  output logic                  neg
);
  localparam int unsigned LW = W + H;
  localparam int unsigned HW = 2 * W - H;

  logic [W-1:0]  mag_a, mag_b;
  logic [LW-1:0] lo_d;
  logic [HW-1:0] hi_d;

  always_comb begin
    mag_a = op_a[W-1] ? (~op_a + 1'b1) : op_a;
    mag_b = op_b[W-1] ? (~op_b + 1'b1) : op_b;
    lo_d  = LW'(mag_a) * LW'(mag_b[H-1:0]);
    hi_d  = HW'(mag_a) * HW'(mag_b[W-1:H]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_lo <= '0;
      pp_hi <= '0;
      neg   <= 1'b0;
    end else if (load) begin
      pp_lo <= lo_d;
      pp_hi <= hi_d;
      neg   <= op_a[W-1] ^ op_b[W-1];
    end
  end
endmodule

// File: rtl/smul_stage2.sv
module smul_stage2 #(
  parameter int unsigned W = 16,
  parameter int unsigned H = W / 2,
  parameter int unsigned F = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [W+H-1:0]        pp_lo,
  input  logic [2*W-H-1:0]      pp_hi,
  input  logic                  neg,
  output logic [W-1:0]          result
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned SW = PW + 1;
  localparam logic signed [SW-1:0] SAT_HI = SW'((2 ** (W - 1)) - 1);
  localparam logic signed [SW-1:0] SAT_LO = -SAT_HI - 1;

  logic [PW-1:0]        mag;
  logic signed [SW-1:0] sprod;
  logic signed [SW-1:0] scaled;
  logic [W-1:0]         sat_d;

  always_comb begin
    mag    = (PW'(pp_hi) << H) + PW'(pp_lo);
    sprod  = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    scaled = sprod >>> F;
    if (scaled > SAT_HI)      sat_d = SAT_HI[W-1:0];
    else if (scaled < SAT_LO) sat_d = SAT_LO[W-1:0];
    else                      sat_d = scaled[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       result <= '0;
    else if (load) result <= sat_d;
  end
endmodule

// File: rtl/q15_sat_mul.sv
module q15_sat_mul
  import smul_pkg::*;
#(
  parameter int unsigned W = SMUL_DATA_W,
  parameter int unsigned F = SMUL_FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int unsigned H = W / 2;

  logic             accept;
  logic [W+H-1:0]   pp_lo;
  logic [2*W-H-1:0] pp_hi;
  logic             neg;

  smul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .accept(accept), .busy(busy), .done(done)
  );

  smul_stage1 #(.W(W), .H(H)) u_s1 (
    .clk(clk), .rst(rst), .load(accept),
    .op_a(op_a), .op_b(op_b),
    .pp_lo(pp_lo), .pp_hi(pp_hi), .neg(neg)
  );

  smul_stage2 #(.W(W), .H(H), .F(F)) u_s2 (
    .clk(clk), .rst(rst), .load(busy),
    .pp_lo(pp_lo), .pp_hi(pp_hi), .neg(neg),
    .result(result)
  );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_busy_single_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  p_done_follows_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> done);

  p_done_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !done);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_ignore_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !busy);
endmodule

bind q15_sat_mul smul_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .busy(busy), .done(done), .result(result)
);

// File: tb/q15_sat_mul_tb.sv
module q15_sat_mul_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_exp = '0;

  always #2 clk = ~clk;

  q15_sat_mul u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    p = p >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return W'(p);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever done is seen.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected done", 16'(done), 16'h0);
      end else begin
        last_exp = exp_q.pop_front();
        check("R4 product", result, last_exp);
      end
    end
  end

  // Driver: called at a negedge, returns at the negedge where done is high.
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    op_a = a; op_b = b; start = 1'b1;
    exp_q.push_back(model(a, b));
    @(negedge clk);
    check("R2 busy after start", 16'(busy), 16'h1);
    start = 1'b0;
    @(negedge clk);
    check("R3 done on second edge", 16'(done), 16'h1);
    check(req, result, model(a, b));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 16'(busy), 16'h0);
    check("R1 done in reset", 16'(done), 16'h0);
    check("R1 result in reset", result, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 result after reset", result, 16'h0);

    issue(16'h4000, 16'h4000, "R4 half times half");
    issue(16'h0003, 16'h0003, "R4 truncation to zero");
    issue(16'hFFFF, 16'h0001, "R4 floor of negative tiny");
    issue(16'hC000, 16'h4000, "R5 mixed signs");
    issue(16'hC000, 16'hA000, "R5 both negative");
    issue(16'h0000, 16'h8000, "R5 zero operand");
    issue(16'h8000, 16'h8000, "R6 saturation corner");
    issue(16'h8000, 16'h7FFF, "R6 min times max");
    issue(16'h1234, 16'hEDCB, "R9 back-to-back issue");
    issue(16'h7FFF, 16'h7FFF, "R9 back-to-back issue");

    // R7: start during busy is dropped.
    @(negedge clk);
    op_a = 16'h2000; op_b = 16'h6000; start = 1'b1;
    exp_q.push_back(model(16'h2000, 16'h6000));
    @(negedge clk);
    op_a = 16'h7FFF; op_b = 16'h8000;
    @(negedge clk);
    start = 1'b0;
    check("R7 result unchanged by dropped start", result, model(16'h2000, 16'h6000));
    @(negedge clk);
    check("R7 no extra done", 16'(done), 16'h0);
    check("R7 no extra busy", 16'(busy), 16'h0);

    // R8: result holds while idle.
    repeat (4) @(negedge clk);
    check("R8 result held", result, model(16'h2000, 16'h6000));
    check("R8 scoreboard drained", 16'(exp_q.size()), 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule